// File: doc/BRIEF.md
# Ramp-Test Capture and Syndrome Accumulator

This block runs the digital side of a static ramp test of an on-chip ADC. A start pulse makes it pulse a reset to an external ramp generator for a fixed number of cycles. It then watches the stream of converter codes. The first nonzero code opens the capture window. Samples keep being accepted until a sample at full-scale code K = 2^N - 1 closes the window. Codes 0 and K are never added to a sum, because they may come from an input outside the converter's range.

The block makes a single pass over the samples and does not buffer them. Each accepted sample is added into one of two accumulators, chosen by whether its code lies in the lower or upper half of the code range. Each accumulator also counts its samples. When capture ends, the two sums are combined into a sum syndrome and a difference syndrome, and the insufficient-sample flag is evaluated. The block then raises done and holds every result until the next start.

A programmable timeout aborts the test if the ramp never leaves zero or never reaches full scale. Coefficient division and per-code linearity figures are done downstream from the registered outputs.

Top module: `rbist_ramp_acc`

## Requirements
- R1: When start_i is seen high while idle or done, ramp_rst_o goes high for exactly RST_CYC cycles (4 by default) starting the next cycle, done_o is low meanwhile, and no sample is taken during that time.
- R2: After the ramp reset, valid samples with code 0 are ignored until the first valid nonzero code. That code is the first sample accepted, unless it equals K.
- R3: Once capture has begun, every valid sample with code in 1..K-1 is accepted. Cycles with code_valid_i low are ignored whatever code_i carries, including K.
- R4: A valid sample with code K ends capture and is not accumulated. Valid samples with code 0 after the lower bound are not accumulated.
- R5: An accepted sample with code at most 2^(N-1)-1 is added to sum_lo_o and counted in cnt_lo_o. Any other accepted sample goes to sum_hi_o and cnt_hi_o. sample_cnt_o is the total of the two counts.
- R6: After capture, synd_sum_o = sum_lo_o + sum_hi_o and synd_diff_o = sum_hi_o - sum_lo_o, both two's-complement signed and N+CNT_W+2 bits wide.
- R7: insuff_o is high in the done state when fewer than 2^(N-2) samples were accepted (64 for N = 8).
- R8: If the search for a nonzero code, or capture itself, lasts timeout_i+1 cycles without its ending event, the test ends with timeout_err_o high. The results hold whatever had been accumulated up to that point.
- R9: done_o rises two cycles after the sample that ends capture was taken. It then stays high, with all results unchanged, until the next start.
- R10: A start clears both sums and counts, the syndromes, timeout_err_o and insuff_o. The cleared values are visible while ramp_rst_o is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start pulse |
| timeout_i | input | TO_W | Phase timeout in cycles, minus one |
| code_i | input | N | ADC output code |
| code_valid_i | input | 1 | code_i holds a sample this cycle |
| ramp_rst_o | output | 1 | Reset to the ramp generator |
| done_o | output | 1 | Test finished, results valid |
| timeout_err_o | output | 1 | Test aborted by the timeout |
| insuff_o | output | 1 | Too few samples accepted |
| sample_cnt_o | output | CNT_W+1 | Total accepted samples |
| cnt_lo_o | output | CNT_W | Accepted samples in the lower half |
| cnt_hi_o | output | CNT_W | Accepted samples in the upper half |
| sum_lo_o | output | N+CNT_W | Sum of lower-half codes |
| sum_hi_o | output | N+CNT_W | Sum of upper-half codes |
| synd_sum_o | output | N+CNT_W+2 | Signed sum syndrome |
| synd_diff_o | output | N+CNT_W+2 | Signed difference syndrome |

## Verification
The bench drives ramps that begin after leading zeros, with zero dips inside the capture window, and with idle cycles that carry a full-scale code while valid is low. A design that opened the window too early, summed zero dips, or closed on an invalid full-scale code would produce wrong counts or end too soon. Coarse ramps that start high or collect fewer than 2^(N-2) samples exercise the half split and the insufficient flag: a code misrouted across the half boundary, or an off-by-one threshold, shows up in the per-half counts. A ramp that stalls, and an input that stays at zero, must both end through the timeout with partial sums held. The bench also checks that done_o rises exactly two cycles after the closing sample and that results do not move while done_o is high.

// File: rtl/rbist_pkg.sv
package rbist_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_RAMP = 3'd1,
    ST_SEEK = 3'd2,
    ST_CAPT = 3'd3,
    ST_CALC = 3'd4,
    ST_DONE = 3'd5
  } rbist_state_e;
endpackage

// File: rtl/rbist_ctrl.sv
module rbist_ctrl
  import rbist_pkg::*;
#(
  parameter int N       = 8,
  parameter int TO_W    = 16,
  parameter int RST_CYC = 4
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [TO_W-1:0] timeout_i,
  input  logic [N-1:0]    code_i,
  input  logic            code_valid_i,
  output logic            clr_o,
  output logic            take_o,
  output logic            calc_o,
  output logic            ramp_rst_o,
  output logic            done_o,
  output logic            to_err_o
);
  localparam logic [N-1:0] CODE_MAX = {N{1'b1}};
  localparam int RC_W = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [RC_W-1:0] RC_LAST = RC_W'(RST_CYC - 1);

  rbist_state_e state_q, state_d;
  logic [RC_W-1:0] rcnt_q, rcnt_d;
  logic [TO_W-1:0] timer_q, timer_d;
  logic            err_q, err_d;

  logic seen_nz, seen_max, t_exp, idle_like;
  assign seen_nz   = code_valid_i && (code_i != '0);
  assign seen_max  = code_valid_i && (code_i == CODE_MAX);
  assign t_exp     = (timer_q == timeout_i);
  assign idle_like = (state_q == ST_IDLE) || (state_q == ST_DONE);

  always_comb begin
    state_d = state_q;
    rcnt_d  = rcnt_q;
    timer_d = timer_q;
    err_d   = err_q;
    case (state_q)
      ST_IDLE, ST_DONE: begin
        if (start_i) begin
          state_d = ST_RAMP;
          rcnt_d  = '0;
          err_d   = 1'b0;
        end
      end
      ST_RAMP: begin
        if (rcnt_q == RC_LAST) begin
          state_d = ST_SEEK;
          timer_d = '0;
        end else begin
          rcnt_d = rcnt_q + 1'b1;
        end
      end
      ST_SEEK: begin
        if (seen_nz) begin
          state_d = seen_max ? ST_CALC : ST_CAPT;
          timer_d = '0;
        end else if (t_exp) begin
          state_d = ST_CALC;
          err_d   = 1'b1;
        end else begin
          timer_d = timer_q + 1'b1;
        end
      end
      ST_CAPT: begin
        if (seen_max) begin
          state_d = ST_CALC;
        end else if (t_exp) begin
          state_d = ST_CALC;
          err_d   = 1'b1;
        end else begin
          timer_d = timer_q + 1'b1;
        end
      end
      ST_CALC: state_d = ST_DONE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      rcnt_q  <= '0;
      timer_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      rcnt_q  <= rcnt_d;
      timer_q <= timer_d;
      err_q   <= err_d;
    end
  end

  assign clr_o      = idle_like && start_i;
  assign take_o     = ((state_q == ST_SEEK) || (state_q == ST_CAPT)) && seen_nz && !seen_max;
  assign calc_o     = (state_q == ST_CALC);
  assign ramp_rst_o = (state_q == ST_RAMP);
  assign done_o     = (state_q == ST_DONE);
  assign to_err_o   = err_q;
endmodule

// File: rtl/rbist_half_acc.sv
module rbist_half_acc #(
  parameter int N     = 8,
  parameter int CNT_W = 12,
  localparam int SUM_W = N + CNT_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             en_i,
  input  logic [N-1:0]     code_i,
  output logic [SUM_W-1:0] sum_o,
  output logic [CNT_W-1:0] cnt_o
);
  logic [SUM_W-1:0] sum_q;
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      sum_q <= '0;
      cnt_q <= '0;
    end else if (en_i) begin
      sum_q <= sum_q + SUM_W'(code_i);
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign sum_o = sum_q;
  assign cnt_o = cnt_q;
endmodule

// File: rtl/rbist_synd.sv
module rbist_synd #(
  parameter int SUM_W    = 20,
  parameter int CNT_W    = 12,
  parameter int MIN_SAMP = 64,
  localparam int SYN_W = SUM_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    clr_i,
  input  logic                    calc_i,
  input  logic [SUM_W-1:0]        sum_lo_i,
  input  logic [SUM_W-1:0]        sum_hi_i,
  input  logic [CNT_W:0]          cnt_tot_i,
  output logic signed [SYN_W-1:0] synd_sum_o,
  output logic signed [SYN_W-1:0] synd_diff_o,
  output logic                    insuff_o
);
  localparam logic [CNT_W:0] MIN_CNT = (CNT_W + 1)'(MIN_SAMP);

  logic signed [SYN_W-1:0] ext_lo, ext_hi;
  assign ext_lo = signed'({2'b00, sum_lo_i});
  assign ext_hi = signed'({2'b00, sum_hi_i});

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      synd_sum_o  <= '0;
      synd_diff_o <= '0;
      insuff_o    <= 1'b0;
    end else if (clr_i) begin
      synd_sum_o  <= '0;
      synd_diff_o <= '0;
      insuff_o    <= 1'b0;
    end else if (calc_i) begin
      synd_sum_o  <= ext_lo + ext_hi;
      synd_diff_o <= ext_hi - ext_lo;
      insuff_o    <= (cnt_tot_i < MIN_CNT);
    end
  end
endmodule

// File: rtl/rbist_ramp_acc.sv
module rbist_ramp_acc #(
  parameter int N       = 8,
  parameter int CNT_W   = 12,
  parameter int TO_W    = 16,
  parameter int RST_CYC = 4,
  localparam int SUM_W = N + CNT_W,
  localparam int SYN_W = SUM_W + 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    start_i,
  input  logic [TO_W-1:0]         timeout_i,
  input  logic [N-1:0]            code_i,
  input  logic                    code_valid_i,
  output logic                    ramp_rst_o,
  output logic                    done_o,
  output logic                    timeout_err_o,
  output logic                    insuff_o,
  output logic [CNT_W:0]          sample_cnt_o,
  output logic [CNT_W-1:0]        cnt_lo_o,
  output logic [CNT_W-1:0]        cnt_hi_o,
  output logic [SUM_W-1:0]        sum_lo_o,
  output logic [SUM_W-1:0]        sum_hi_o,
  output logic signed [SYN_W-1:0] synd_sum_o,
  output logic signed [SYN_W-1:0] synd_diff_o
);
  localparam int MIN_SAMP = 2 ** (N - 2);
  localparam logic [N-1:0] HALF_TOP = {1'b0, {(N-1){1'b1}}};

  logic clr, take, calc, hi_sel;
  logic [SUM_W-1:0] sum_w [2];
  logic [CNT_W-1:0] cnt_w [2];

  rbist_ctrl #(.N(N), .TO_W(TO_W), .RST_CYC(RST_CYC)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start_i),
    .timeout_i    (timeout_i),
    .code_i       (code_i),
    .code_valid_i (code_valid_i),
    .clr_o        (clr),
    .take_o       (take),
    .calc_o       (calc),
    .ramp_rst_o   (ramp_rst_o),
    .done_o       (done_o),
    .to_err_o     (timeout_err_o)
  );

  assign hi_sel = (code_i > HALF_TOP);

  for (genvar g = 0; g < 2; g++) begin : g_half
    rbist_half_acc #(.N(N), .CNT_W(CNT_W)) u_acc (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr),
      .en_i   (take && (hi_sel == (g == 1))),
      .code_i (code_i),
      .sum_o  (sum_w[g]),
      .cnt_o  (cnt_w[g])
    );
  end

  assign sum_lo_o     = sum_w[0];
  assign sum_hi_o     = sum_w[1];
  assign cnt_lo_o     = cnt_w[0];
  assign cnt_hi_o     = cnt_w[1];
  assign sample_cnt_o = {1'b0, cnt_w[0]} + {1'b0, cnt_w[1]};

  rbist_synd #(.SUM_W(SUM_W), .CNT_W(CNT_W), .MIN_SAMP(MIN_SAMP)) u_synd (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (clr),
    .calc_i      (calc),
    .sum_lo_i    (sum_w[0]),
    .sum_hi_i    (sum_w[1]),
    .cnt_tot_i   (sample_cnt_o),
    .synd_sum_o  (synd_sum_o),
    .synd_diff_o (synd_diff_o),
    .insuff_o    (insuff_o)
  );
endmodule

// File: rtl/rbist_ramp_acc_chk.sv
module rbist_ramp_acc_chk #(
  parameter int N     = 8,
  parameter int CNT_W = 12,
  localparam int SUM_W = N + CNT_W,
  localparam int SYN_W = SUM_W + 2
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    start_i,
  input logic                    ramp_rst_o,
  input logic                    done_o,
  input logic                    insuff_o,
  input logic [CNT_W:0]          sample_cnt_o,
  input logic [SUM_W-1:0]        sum_lo_o,
  input logic [SUM_W-1:0]        sum_hi_o,
  input logic signed [SYN_W-1:0] synd_sum_o,
  input logic signed [SYN_W-1:0] synd_diff_o
);
  localparam int MIN_SAMP = 2 ** (N - 2);

  AST_RAMP_AFTER_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ramp_rst_o) |-> $past(start_i)) else $error("ramp reset without start"); // R1

  AST_RAMP_DONE_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ramp_rst_o && done_o)) else $error("ramp reset while done"); // R1

  AST_CLEAR_IN_RAMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ramp_rst_o |-> (sum_lo_o == '0) && (sum_hi_o == '0) && (sample_cnt_o == '0)) else $error("not cleared"); // R10

  AST_SYND_SUM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (synd_sum_o == signed'({2'b00, sum_lo_o}) + signed'({2'b00, sum_hi_o}))) else $error("sum syndrome"); // R6

  AST_SYND_DIFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (synd_diff_o == signed'({2'b00, sum_hi_o}) - signed'({2'b00, sum_lo_o}))) else $error("diff syndrome"); // R6

  AST_INSUFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (insuff_o == (int'(sample_cnt_o) < MIN_SAMP))) else $error("insufficient flag"); // R7

  AST_HOLD_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && $past(done_o)) |-> ($stable(sum_lo_o) && $stable(sum_hi_o) && $stable(synd_diff_o))) else $error("results moved"); // R9
endmodule

bind rbist_ramp_acc rbist_ramp_acc_chk #(.N(N), .CNT_W(CNT_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .ramp_rst_o   (ramp_rst_o),
  .done_o       (done_o),
  .insuff_o     (insuff_o),
  .sample_cnt_o (sample_cnt_o),
  .sum_lo_o     (sum_lo_o),
  .sum_hi_o     (sum_hi_o),
  .synd_sum_o   (synd_sum_o),
  .synd_diff_o  (synd_diff_o)
);

// File: tb/rbist_ramp_acc_tb_top.sv
module rbist_ramp_acc_tb_top;
  localparam int N = 8;
  localparam int CNT_W = 12;
  localparam int TO_W = 16;
  localparam int RST_CYC = 4;
  localparam int SUM_W = N + CNT_W;
  localparam int SYN_W = SUM_W + 2;
  localparam int KMAX = 255;
  localparam int HALF_TOP = 127;

  typedef struct packed {
    logic [15:0] lead;
    logic [15:0] first;
    logic [15:0] step;
    logic [15:0] dip;
    logic [15:0] gap;
    logic [15:0] stop_at;
    logic        exp_to;
    logic        exp_ins;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t TBL [NV] = '{
    '{16'd5, 16'd1,   16'd1, 16'd0,  16'd0, 16'd0,   1'b0, 1'b0},
    '{16'd0, 16'd3,   16'd2, 16'd0,  16'd1, 16'd0,   1'b0, 1'b0},
    '{16'd2, 16'd10,  16'd4, 16'd0,  16'd0, 16'd0,   1'b0, 1'b1},
    '{16'd7, 16'd1,   16'd1, 16'd16, 16'd0, 16'd0,   1'b0, 1'b0},
    '{16'd3, 16'd1,   16'd1, 16'd0,  16'd0, 16'd100, 1'b1, 1'b0},
    '{16'd0, 16'd0,   16'd0, 16'd0,  16'd0, 16'd0,   1'b1, 1'b1},
    '{16'd3, 16'd200, 16'd1, 16'd0,  16'd0, 16'd0,   1'b0, 1'b1}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic [TO_W-1:0] timeout_i = 16'd600;
  logic [N-1:0] code_i = '0;
  logic code_valid_i = 1'b0;
  logic ramp_rst_o, done_o, timeout_err_o, insuff_o;
  logic [CNT_W:0] sample_cnt_o;
  logic [CNT_W-1:0] cnt_lo_o, cnt_hi_o;
  logic [SUM_W-1:0] sum_lo_o, sum_hi_o;
  logic signed [SYN_W-1:0] synd_sum_o, synd_diff_o;

  int n_chk = 0;
  int n_err = 0;

  always #4 clk = ~clk;

  rbist_ramp_acc #(.N(N), .CNT_W(CNT_W), .TO_W(TO_W), .RST_CYC(RST_CYC)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .timeout_i(timeout_i),
    .code_i(code_i), .code_valid_i(code_valid_i), .ramp_rst_o(ramp_rst_o),
    .done_o(done_o), .timeout_err_o(timeout_err_o), .insuff_o(insuff_o),
    .sample_cnt_o(sample_cnt_o), .cnt_lo_o(cnt_lo_o), .cnt_hi_o(cnt_hi_o),
    .sum_lo_o(sum_lo_o), .sum_hi_o(sum_hi_o), .synd_sum_o(synd_sum_o),
    .synd_diff_o(synd_diff_o)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    longint s0 = 0, s1 = 0;
    int c0 = 0, c1 = 0, rc = 0, c = 0, k = 0, i = 0;
    bit started = 0, ended = 0, stop = 0;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk("R10", $sformatf("v%0d sum_lo cleared", idx), longint'(sum_lo_o), 0);
    chk("R10", $sformatf("v%0d sum_hi cleared", idx), longint'(sum_hi_o), 0);
    chk("R10", $sformatf("v%0d flags cleared", idx), longint'({timeout_err_o, insuff_o, done_o}), 0);
    while (ramp_rst_o && rc < 100) begin
      rc++;
      @(negedge clk);
    end
    chk("R1", $sformatf("v%0d ramp reset cycles", idx), rc, RST_CYC);
    while (!ended && !stop && i < 300) begin
      if (i < int'(v.lead)) c = 0;
      else begin
        k = i - int'(v.lead);
        c = int'(v.first) + int'(v.step) * k;
        if (c > KMAX) c = KMAX;
        if (v.stop_at != 0 && c > int'(v.stop_at)) stop = 1;
        if (v.dip != 0 && (k % int'(v.dip)) == int'(v.dip) - 1 && c != KMAX) c = 0;
      end
      if (!stop) begin
        if (v.gap != 0) begin
          code_valid_i = 1'b0;
          code_i = 8'hFF; // R3: full-scale code with valid low
          @(negedge clk);
        end
        code_valid_i = 1'b1;
        code_i = N'(c);
        if (c != 0) started = 1;
        if (started) begin
          if (c == KMAX) ended = 1;
          else if (c != 0) begin
            if (c <= HALF_TOP) begin s0 += c; c0++; end
            else begin s1 += c; c1++; end
          end
        end
        @(negedge clk);
        i++;
      end
    end
    code_valid_i = 1'b0;
    code_i = '0;
    if (ended) begin
      chk("R9", $sformatf("v%0d done low one cycle after end", idx), longint'(done_o), 0);
      @(negedge clk);
      chk("R9", $sformatf("v%0d done high two cycles after end", idx), longint'(done_o), 1);
    end else begin
      for (int w = 0; w < 3000 && !done_o; w++) @(negedge clk);
      chk("R8", $sformatf("v%0d done after timeout", idx), longint'(done_o), 1);
    end
    chk("R8", $sformatf("v%0d timeout flag", idx), longint'(timeout_err_o), longint'(v.exp_to));
    chk("R5", $sformatf("v%0d sum_lo", idx), longint'(sum_lo_o), s0);
    chk("R5", $sformatf("v%0d sum_hi", idx), longint'(sum_hi_o), s1);
    chk("R5", $sformatf("v%0d cnt_lo", idx), longint'(cnt_lo_o), c0);
    chk("R5", $sformatf("v%0d cnt_hi", idx), longint'(cnt_hi_o), c1);
    chk("R2", $sformatf("v%0d sample count", idx), longint'(sample_cnt_o), c0 + c1);
    chk("R6", $sformatf("v%0d sum syndrome", idx), longint'(synd_sum_o), s0 + s1);
    chk("R6", $sformatf("v%0d diff syndrome", idx), longint'(synd_diff_o), s1 - s0);
    chk("R7", $sformatf("v%0d insufficient flag", idx), longint'(insuff_o), longint'(v.exp_ins));
    chk("R7", $sformatf("v%0d model threshold", idx), longint'((c0 + c1) < 64), longint'(v.exp_ins));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [SUM_W-1:0] held_lo;
    logic signed [SYN_W-1:0] held_sd;
    repeat (3) @(negedge clk);
    chk("R10", "reset done", longint'(done_o), 0);
    chk("R1", "reset ramp", longint'(ramp_rst_o), 0);
    chk("R10", "reset sums", longint'(sum_lo_o) + longint'(sum_hi_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    for (int t = 0; t < NV; t++) run_vec(TBL[t], t);

    // R9: results held while done, with no start
    held_lo = sum_lo_o;
    held_sd = synd_diff_o;
    repeat (6) @(negedge clk);
    chk("R9", "done held", longint'(done_o), 1);
    chk("R9", "sum_lo held", longint'(sum_lo_o), longint'(held_lo));
    chk("R9", "diff syndrome held", longint'(synd_diff_o), longint'(held_sd));

    // R4: first nonzero code is full scale: nothing accepted
    run_vec('{16'd4, 16'd255, 16'd0, 16'd0, 16'd0, 16'd0, 1'b0, 1'b1}, 99);
    chk("R4", "full-scale first code count", longint'(sample_cnt_o), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_err);
    $finish;
  end
endmodule